// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable integer ratio N = B·P + A and marks the end of every N-clock frame with a one-cycle pulse on `fb_pulse`. A phase detector can use that pulse as its feedback edge. The division is split the classic way. A dual-modulus prescaler counts either P+1 or P input clocks. A swallow counter holding A keeps the prescaler in its P+1 mode for the first A prescaler periods of a frame. A main counter holding B counts all prescaler periods and closes the frame. The prescaler is a synchronous divide-by-4/5 core followed by a binary extension stage of 2, 4 or 8. This gives the modulus pairs 8/9, 16/17 and 32/33.

Software writes a prescaler select, A and B, and strobes `load`. A legal setting is kept in pending registers. The running counters pick it up only at the next frame reload, so the frame in progress is never disturbed. An illegal setting raises `cfg_err` and is discarded.

The frame controller is a two-state machine. PH_SWALLOW is the phase in which the prescaler divides by P+1, and it is left for PH_MAIN when the swallow count runs out. PH_MAIN is the phase in which the prescaler divides by P. The frame reload is a transition taken from either state when the main count expires. It enters PH_SWALLOW when the new A is nonzero and PH_MAIN otherwise.

Top module: `pulse_swallow_divider`

## Requirements
- R1: After a synchronous reset, `fb_pulse` and `cfg_err` are low and the block runs with select 00, A = 0 and B = 3. The first pulse appears after the 24th rising edge following reset release, and pulses then repeat every 24 clocks.
- R2: With a setting in force, consecutive `fb_pulse` rises are exactly B·P + A clocks apart, where select 00 gives P = 8, 01 gives P = 16 and 10 gives P = 32. No interval is ever shorter than 24 clocks.
- R3: `fb_pulse` is high for exactly one clock per frame.
- R4: The corner settings A = 0 (every prescaler period at P) and A = B (every prescaler period at P+1) both give B·P + A. While the P+1 mode is selected, the mode input of the prescaler changes only at a prescaler output.
- R5: A `load` with select other than 11, B ≥ 3 and B ≥ A is accepted, and `cfg_err` is low from the next clock.
- R6: A `load` with select 11, B < 3 or A > B sets `cfg_err` from the next clock and leaves the pending setting unchanged, so the interval stays at its previous value. `cfg_err` changes only on a `load`.
- R7: An accepted setting takes effect only at the next frame reload. The frame during which it is loaded keeps its old length, and the following frame has the new length.
- R8: For each P, every ratio N ≥ P² − P can be reached with B = N div P and A = N mod P. This is checked at N = P² − P and N = P² − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 2 | Prescaler select: 00 = 8/9, 01 = 16/17, 10 = 32/33, 11 illegal |
| a_in | input | 5 | Swallow count A, 0 to 31 |
| b_in | input | 13 | Main count B, 3 to 8191 |
| load | input | 1 | Strobe that samples psel, a_in and b_in |
| fb_pulse | output | 1 | One-clock pulse at the end of each frame of N clocks |
| cfg_err | output | 1 | High after the last load was rejected |

## Verification
The assertions assume that `load` is a single-clock strobe and that the select, A and B inputs are stable while it is high. They also assume the running ratio is never below 24, which every legal setting guarantees. The bench drives `load` for exactly one clock from a falling edge. Its random pairs clamp A to at most B and draw B from 3 upward. It sends illegal settings only as directed cases, and checks that they are discarded.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [0:0] {
        PH_SWALLOW = 1'b0,
        PH_MAIN    = 1'b1
    } phase_e;

    localparam int SEL_W = 2;
    localparam int EXT_W = 3;
    localparam int CORE_W = 3;
    localparam logic [SEL_W-1:0] SEL_BAD = 2'd3;

    // last count of the extension stage: divide by 2, 4 or 8
    function automatic logic [EXT_W-1:0] ext_last(input logic [SEL_W-1:0] sel);
        logic [EXT_W-1:0] r;
        unique case (sel)
            2'd0:    r = 3'd1;
            2'd1:    r = 3'd3;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             modctl,
    input  logic [EXT_W-1:0] ext_max,
    output logic             pout
);
    logic [CORE_W-1:0] core_q;
    logic [EXT_W-1:0]  ext_q;
    logic [CORE_W-1:0] core_lim;
    logic              ext_end;
    logic              core_wrap;

    always_comb begin
        ext_end   = (ext_q == ext_max);
        // the 4/5 core stretches to five clocks once per prescaler period
        core_lim  = (modctl && ext_end) ? CORE_W'(4) : CORE_W'(3);
        core_wrap = (core_q == core_lim);
        pout      = core_wrap && ext_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
            ext_q  <= '0;
        end else if (core_wrap) begin
            core_q <= '0;
            ext_q  <= ext_end ? '0 : ext_q + 1'b1;
        end else begin
            core_q <= core_q + 1'b1;
        end
    end
endmodule

// File: rtl/psd_config.sv
module psd_config
    import psd_pkg::*;
#(
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int B_MIN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [SEL_W-1:0] pend_sel,
    output logic [A_W-1:0]   pend_a,
    output logic [B_W-1:0]   pend_b,
    output logic             cfg_err
);
    logic legal;

    always_comb begin
        legal = (sel_in != SEL_BAD)
             && (b_in >= B_W'(B_MIN))
             && (B_W'(a_in) <= b_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_sel <= '0;
            pend_a   <= '0;
            pend_b   <= B_W'(B_MIN);
            cfg_err  <= 1'b0;
        end else if (load) begin
            cfg_err <= !legal;
            if (legal) begin
                pend_sel <= sel_in;
                pend_a   <= a_in;
                pend_b   <= b_in;
            end
        end
    end
endmodule

// File: rtl/psd_frame_ctrl.sv
module psd_frame_ctrl
    import psd_pkg::*;
#(
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int B_MIN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pout,
    input  logic [SEL_W-1:0] pend_sel,
    input  logic [A_W-1:0]   pend_a,
    input  logic [B_W-1:0]   pend_b,
    output logic             modctl,
    output logic [SEL_W-1:0] act_sel,
    output logic             frame_end
);
    phase_e           phase_q, phase_d;
    logic [A_W-1:0]   a_q, a_d;
    logic [B_W-1:0]   b_q, b_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    // next-state process
    always_comb begin
        phase_d   = phase_q;
        a_d       = a_q;
        b_d       = b_q;
        sel_d     = sel_q;
        frame_end = pout && (b_q == B_W'(1));
        if (frame_end) begin
            // reload: pending setting enters here and only here
            a_d     = pend_a;
            b_d     = pend_b;
            sel_d   = pend_sel;
            phase_d = (pend_a != '0) ? PH_SWALLOW : PH_MAIN;
        end else if (pout) begin
            b_d = b_q - 1'b1;
            unique case (phase_q)
                PH_SWALLOW: begin
                    a_d = a_q - 1'b1;
                    if (a_q == A_W'(1)) phase_d = PH_MAIN;
                end
                PH_MAIN: begin
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_MAIN;
            a_q     <= '0;
            b_q     <= B_W'(B_MIN);
            sel_q   <= '0;
        end else begin
            phase_q <= phase_d;
            a_q     <= a_d;
            b_q     <= b_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        modctl  = (phase_q == PH_SWALLOW);
        act_sel = sel_q;
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import psd_pkg::*;
#(
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int B_MIN = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     psel,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           load,
    output logic           fb_pulse,
    output logic           cfg_err
);
    logic [SEL_W-1:0] pend_sel;
    logic [A_W-1:0]   pend_a;
    logic [B_W-1:0]   pend_b;
    logic [SEL_W-1:0] act_sel;
    logic             modctl;
    logic             pout;
    logic             frame_end;

    psd_config #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
        .clk(clk), .rst(rst), .load(load), .sel_in(psel),
        .a_in(a_in), .b_in(b_in),
        .pend_sel(pend_sel), .pend_a(pend_a), .pend_b(pend_b),
        .cfg_err(cfg_err)
    );

    psd_prescaler u_pre (
        .clk(clk), .rst(rst), .modctl(modctl),
        .ext_max(ext_last(act_sel)), .pout(pout)
    );

    psd_frame_ctrl #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_ctrl (
        .clk(clk), .rst(rst), .pout(pout),
        .pend_sel(pend_sel), .pend_a(pend_a), .pend_b(pend_b),
        .modctl(modctl), .act_sel(act_sel), .frame_end(frame_end)
    );

    // output process
    always_ff @(posedge clk) begin
        if (rst) fb_pulse <= 1'b0;
        else     fb_pulse <= frame_end;
    end
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int A_W   = 5,
    parameter int B_W   = 13,
    parameter int B_MIN = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [1:0]     psel,
    input logic [A_W-1:0] a_in,
    input logic [B_W-1:0] b_in,
    input logic           load,
    input logic           fb_pulse,
    input logic           cfg_err,
    input logic           modctl,
    input logic           pout
);
    localparam int GAP_W = 20;
    logic [GAP_W-1:0] gap;
    logic             ok_set;

    always_comb ok_set = (psel != 2'd3) && (b_in >= B_W'(B_MIN)) && (B_W'(a_in) <= b_in);

    always_ff @(posedge clk) begin
        if (rst || fb_pulse) gap <= '0;
        else if (gap != '1) gap <= gap + 1'b1;
    end

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R2
    min_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |-> gap >= GAP_W'(23));

    // R5
    load_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (load && ok_set) |=> !cfg_err);

    // R6
    load_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !ok_set) |=> cfg_err);

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_err));

    // R4
    mode_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !pout |=> $stable(modctl));
endmodule

bind pulse_swallow_divider psd_checker #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .a_in(a_in), .b_in(b_in),
    .load(load), .fb_pulse(fb_pulse), .cfg_err(cfg_err),
    .modctl(modctl), .pout(pout)
);

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int SEED       = 1357;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  psel = '0;
    logic [4:0]  a_in = '0;
    logic [12:0] b_in = 13'd3;
    logic        load = 1'b0;
    logic        fb_pulse;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;
    int total    = 0;
    int cur_n    = 24;
    logic prev_pulse = 1'b0;

    pulse_swallow_divider i_pulse_swallow_divider (
        .clk(clk), .rst(rst), .psel(psel), .a_in(a_in), .b_in(b_in),
        .load(load), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int p_of(input logic [1:0] s);
        return 8 << s;
    endfunction

    function automatic int ratio(input logic [1:0] s, input int a, input int b);
        return b * p_of(s) + a;
    endfunction

    function automatic bit legal(input logic [1:0] s, input int a, input int b);
        return (s != 2'd3) && (b >= 3) && (a <= b);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        edges++;
        total++;
        if (total > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", total, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // R3: pulse width watched continuously
    always @(negedge clk) begin
        if (!rst && prev_pulse && fb_pulse)
            chk(1'b0, "R3", 2, 1);
        prev_pulse = fb_pulse;
    end

    task automatic next_pulse(output int t);
        do @(negedge clk); while (!fb_pulse);
        t = edges;
    endtask

    task automatic do_load(input logic [1:0] s, input int a, input int b);
        psel = s;
        a_in = 5'(a);
        b_in = 13'(b);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // load right after a pulse, check old frame then new frame
    task automatic apply(input logic [1:0] s, input int a, input int b, input string req);
        int t0, t1, t2, newn;
        bit ok;
        ok = legal(s, a, b);
        newn = ok ? ratio(s, a, b) : cur_n;
        next_pulse(t0);
        do_load(s, a, b);
        chk(cfg_err == !ok, ok ? "R5" : "R6", int'(cfg_err), int'(!ok));
        next_pulse(t1);
        chk(t1 - t0 == cur_n, "R7", t1 - t0, cur_n);
        next_pulse(t2);
        chk(t2 - t1 == newn, req, t2 - t1, newn);
        cur_n = newn;
    endtask

    initial begin
        int t, t2, r;
        logic [1:0] s;
        int a, b, n;
        r = $urandom(SEED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        edges = 0;
        // R1: reset state
        chk(fb_pulse == 1'b0, "R1", int'(fb_pulse), 0);
        chk(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
        next_pulse(t);
        chk(t == 24, "R1", t, 24);
        next_pulse(t2);
        chk(t2 - t == 24, "R1", t2 - t, 24);

        // R4: corners A = 0 and A = B
        apply(2'd0, 0, 3, "R4");
        apply(2'd0, 31, 31, "R4");
        apply(2'd1, 5, 5, "R4");
        apply(2'd2, 0, 4, "R4");

        // R8: lowest contiguous ratio and the ratio just below P*P
        for (int k = 0; k < 3; k++) begin
            s = 2'(k);
            n = p_of(s) * p_of(s) - p_of(s);
            apply(s, n % p_of(s), n / p_of(s), "R8");
            n = p_of(s) * p_of(s) - 1;
            apply(s, n % p_of(s), n / p_of(s), "R8");
        end

        // R6: illegal settings are discarded
        apply(2'd3, 1, 10, "R6");
        apply(2'd0, 0, 2, "R6");
        apply(2'd1, 9, 8, "R6");

        // R2: random pairs per select
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 4; j++) begin
                b = 3 + int'($urandom % 28);
                a = int'($urandom % 32);
                if (a > b) a = b;
                apply(2'(k), a, b, "R2");
            end
        end

        // R5: a legal load after a rejected one clears the flag
        apply(2'd2, 7, 7, "R6");
        apply(2'd3, 0, 5, "R6");
        apply(2'd0, 2, 9, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule